// File: doc/BRIEF.md
# Stereo Serial Audio Output Port

This block sends a pair of signed 18-bit audio samples, left and right, that were captured at the same instant, over one serial data line. A frame is 64 bit clocks long. The left word goes out in the half of the frame where the frame clock is high, and the right word in the half where it is low. Each half is 32 bit clocks wide. Words go out most significant bit first, and the positions after the chosen word length are filled with zeros.

Everything runs on one system clock. The bit clock reaches the block as a one-cycle strobe that marks each falling edge of the bit clock. In master mode the block counts those strobes and drives the frame clock itself. In slave mode it samples an external frame clock on each strobe and realigns its bit position on every edge of that clock. New samples are written into a holding pair with a load strobe. The holding pair is copied into the shift pair only at frame start, so a frame never carries halves from two different sample periods.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset, `sdata` is 0 and `frame_clk_o` is 0. In master mode the first bit-clock strobe after reset starts a frame with bit 0 of the left word.
- R2: In master mode `frame_clk_o` changes only on bit-clock strobes. It is 1 for 32 strobes (left half) and then 0 for 32 strobes (right half), repeating every 64 strobes.
- R3: The left word goes out in the left half and the right word in the right half, most significant bit (sample bit 17) first. Bit 0 of each half is driven on the strobe where the frame clock changes.
- R4: With `word18`=1, bit positions 0..17 of a half carry sample bits 17..0 and positions 18..31 carry 0.
- R5: With `word18`=0, positions 0..15 carry sample bits 17..2 and positions 16..31 carry 0.
- R6: Both holding samples are copied together at frame start (the left half's bit 0). A load made during a frame does not change the frame in progress and is sent in the next frame.
- R7: `sdata` and `frame_clk_o` change only in the clock cycle after a bit-clock strobe.
- R8: In slave mode, a strobe that samples `ext_frame_clk` changed from the previous strobe to 1 starts a frame at left bit 0. A change to 0 moves to right bit 0. Both hold even when the internal count disagrees.
- R9: In slave mode `frame_clk_o` stays 0.
- R10: Without a frame-clock edge, slave mode advances one bit position per strobe, the same as master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 = follow external frame clock, 0 = master |
| word18 | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| bclk_fall | input | 1 | One-cycle strobe per bit-clock falling edge |
| ext_frame_clk | input | 1 | External frame clock (slave mode) |
| smp_load | input | 1 | Writes `smp_left`/`smp_right` into the holding pair |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| sdata | output | 1 | Serial data bit |
| frame_clk_o | output | 1 | Frame clock driven in master mode |

## Verification
Both outputs are registered on the strobe cycle itself, so each result appears one system clock after the edge that samples `bclk_fall`. The bench drives every input on the falling clock edge and reads the outputs on the next falling edge, once per bit position. It reads them again on an idle cycle after each strobe to confirm nothing moved (R7). Loads are issued only on cycles with no strobe, which keeps the frame-start copy from landing on the same edge as a load.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int SAMPLE_W   = 18,
  parameter int SHORT_W    = 16,
  parameter int FRAME_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slave_mode,
  input  logic                word18,
  input  logic                bclk_fall,
  input  logic                ext_frame_clk,
  input  logic                smp_load,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                sdata,
  output logic                frame_clk_o
);
  localparam int SLOT_BITS = FRAME_BITS / 2;
  localparam int PW = $clog2(FRAME_BITS);
  localparam int IW = $clog2(SLOT_BITS);

  logic [PW-1:0]       pos, nxt_pos;
  logic                lr_q;
  logic [SAMPLE_W-1:0] hold_l, hold_r, frm_l, frm_r;
  logic [SAMPLE_W-1:0] word, shifted;
  logic [IW-1:0]       idx;
  logic                lr_edge, frame_start, in_len, nxt_bit;

  assign lr_edge     = slave_mode && (ext_frame_clk != lr_q);
  assign nxt_pos     = lr_edge ? (ext_frame_clk ? '0 : PW'(SLOT_BITS)) : pos + 1'b1;
  assign frame_start = (nxt_pos == '0);
  assign idx         = nxt_pos[IW-1:0];
  assign word        = nxt_pos[PW-1] ? frm_r : (frame_start ? hold_l : frm_l);
  assign shifted     = word << idx;
  assign in_len      = word18 ? (int'(idx) < SAMPLE_W) : (int'(idx) < SHORT_W);
  assign nxt_bit     = in_len & shifted[SAMPLE_W-1];
  assign frame_clk_o = ~slave_mode & ~pos[PW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (smp_load) begin
      hold_l <= smp_left;
      hold_r <= smp_right;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '1;
      lr_q  <= 1'b0;
      sdata <= 1'b0;
      frm_l <= '0;
      frm_r <= '0;
    end else if (bclk_fall) begin
      pos   <= nxt_pos;
      lr_q  <= ext_frame_clk;
      sdata <= nxt_bit;
      if (frame_start) begin
        frm_l <= hold_l;
        frm_r <= hold_r;
      end
    end
  end

  p_quiet_between_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> ($stable(sdata) && $stable(pos)));

  p_master_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && bclk_fall && pos == '1) |=> (pos == '0));

  p_slave_left_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && bclk_fall && ext_frame_clk && !lr_q) |=> (pos == '0));

  p_slave_right_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && bclk_fall && !ext_frame_clk && lr_q) |=> (pos == PW'(SLOT_BITS)));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos[IW-1:0]) >= SAMPLE_W) |-> !sdata);

  p_frame_pair_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> ($stable(frm_l) && $stable(frm_r)));
endmodule

// File: tb/stereo_serial_tx_tb.sv
module stereo_serial_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, slave_mode = 1'b0, word18 = 1'b1, bclk_fall = 1'b0;
  logic ext_frame_clk = 1'b0, smp_load = 1'b0;
  logic [17:0] smp_left = '0, smp_right = '0;
  logic sdata, frame_clk_o;

  int checks = 0, failures = 0, cycles = 0;
  int m_pos;
  logic m_prev;
  logic [17:0] hl, hr, fl, fr;
  string tag_over = "";

  always #4 clk = ~clk;

  stereo_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .word18(word18),
    .bclk_fall(bclk_fall), .ext_frame_clk(ext_frame_clk), .smp_load(smp_load),
    .smp_left(smp_left), .smp_right(smp_right), .sdata(sdata), .frame_clk_o(frame_clk_o));

  function automatic logic exp_bit(logic [17:0] w, int i, logic w18);
    int len = w18 ? 18 : 16;
    return (i < len) ? w[17-i] : 1'b0;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bclk_fall = 1'b0; smp_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pos = 63; m_prev = 1'b0; hl = '0; hr = '0; fl = '0; fr = '0;
    chk(sdata == 1'b0, "R1 sdata", sdata, 0);
    chk(frame_clk_o == 1'b0, "R1 frame_clk_o", frame_clk_o, 0);
  endtask

  task automatic load(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk); smp_load = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk); smp_load = 1'b0; hl = l; hr = r;
  endtask

  task automatic strobe(input logic lr);
    logic eb, ef;
    int i;
    string t;
    @(negedge clk); bclk_fall = 1'b1; ext_frame_clk = lr;
    if (slave_mode && lr != m_prev) m_pos = lr ? 0 : 32;
    else m_pos = (m_pos + 1) % 64;
    m_prev = lr;
    if (m_pos == 0) begin fl = hl; fr = hr; end
    i = m_pos % 32;
    eb = exp_bit(m_pos >= 32 ? fr : fl, i, word18);
    ef = slave_mode ? 1'b0 : (m_pos < 32);
    @(negedge clk); bclk_fall = 1'b0;
    t = (tag_over != "") ? tag_over : (i >= (word18 ? 18 : 16)) ? (word18 ? "R4" : "R5") : "R3";
    chk(sdata == eb, {t, " sdata"}, sdata, eb);
    chk(frame_clk_o == ef, slave_mode ? "R9 frame_clk_o" : "R2 frame_clk_o", frame_clk_o, ef);
    @(negedge clk);
    chk(sdata == eb && frame_clk_o == ef, "R7 hold between strobes", {sdata, frame_clk_o}, {eb, ef});
  endtask

  task automatic master_frames(input int n);
    for (int k = 0; k < n * 64; k++) strobe(1'b0);
  endtask

  task automatic slave_frame(input int left_len, input int right_len);
    for (int k = 0; k < left_len; k++) strobe(1'b1);
    for (int k = 0; k < right_len; k++) strobe(1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state, then master 18-bit frames (R2, R3, R4)
    slave_mode = 1'b0; word18 = 1'b1;
    do_reset();
    load(18'h2A5C3, 18'h15A3C);
    master_frames(1);
    for (int f = 0; f < 3; f++) begin
      load(18'($urandom), 18'($urandom));
      master_frames(1);
    end
    // corner values: most negative and most positive
    load(18'h20000, 18'h1FFFF);
    master_frames(1);
    // R6: load in mid-frame must not disturb the current frame
    load(18'h3C3C3, 18'h0F0F0);
    for (int k = 0; k < 40; k++) strobe(1'b0);
    load(18'h00001, 18'h3FFFE);
    tag_over = "R6";
    for (int k = 0; k < 24; k++) strobe(1'b0);
    master_frames(1);
    tag_over = "";
    // R5: 16-bit mode
    word18 = 1'b0;
    for (int f = 0; f < 3; f++) begin
      load(18'($urandom), 18'($urandom));
      master_frames(1);
    end
    // R8, R9, R10: slave mode
    slave_mode = 1'b1; word18 = 1'b1;
    do_reset();
    load(18'h2B6D1, 18'h1249F);
    slave_frame(32, 32);
    for (int f = 0; f < 3; f++) begin
      load(18'($urandom), 18'($urandom));
      slave_frame(32, 32);
    end
    // R8: resync on short and long halves
    tag_over = "R8";
    load(18'h3FFFF, 18'h2AAAA);
    slave_frame(20, 10);
    slave_frame(32, 40);
    word18 = 1'b0;
    load(18'($urandom), 18'($urandom));
    slave_frame(5, 32);
    tag_over = "";
    slave_frame(32, 32);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule